// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Front End

This block is the register-side front end of a multi-channel, descriptor-driven DMA controller. Software reaches it through a 32-bit register bus on which every channel occupies its own 8 KiB window. For each channel the block holds the descriptor pointers, a two-bit configuration, the interrupt cause, mask and acknowledge logic, and a one-hot channel state. Writes to the command and stream-command registers are decoded into descriptor-load, start and continue operations.

Descriptor fetch and data movement belong to a separate transfer engine. This block presents one load request at a time to that engine, with an operation, a channel and an address. The engine answers with a done pulse and the decoded descriptor fields. The engine also reports per-channel events: interrupt causes and the end of a descriptor list. Those events set the raw interrupt bits and the end-of-list flags held in this block.

Top module: `dmaf_front`

## Requirements
- R1: After reset, every channel's status register reads 0x101 and its pointer registers read 0. `irq`, `eng_req`, `bus_wait` and `bus_err` are low.
- R2: The channel is selected by address bits from bit 13 upward, and the register by address bits [7:2]. The byte offsets are: current data pointer 0x00, saved pointer 0x58, saved buffer 0x5C, group 0x60, group-down 0x7C, command 0x80, config 0x84, status 0x88, mask 0x8C, acknowledge 0x90, raw cause 0x94, masked cause 0x98, stream command 0x9C. Each channel keeps its own pointer values. A channel index at or above NUM_CH ignores writes and reads 0.
- R3: A config write stores bits [1:0]. If bit1 is set, the state becomes stopped. If bit0 is clear, the state becomes reset, and this overrides stopped. A config write with bit0 set and bit1 clear leaves the state unchanged.
- R4: Status reads the one-hot state in bits [2:0] (reset 1, stopped 2, running 4), the channel end-of-list flag in bit 5, and the constant command-source value 1 in bits [15:8]. All other bits read 0.
- R5: An engine event sets the raw cause bits of its channel. The masked-cause register reads raw AND mask. `irq[c]` is the OR of the masked bits of channel c.
- R6: Writing ones to the acknowledge register clears the matching raw bits. The acknowledge register always reads 0. Writes to the raw and masked registers have no effect. A cause set in the same cycle as an acknowledge write stays set.
- R7: A stream-command write with bit 8 or bit 6 set loads the data descriptor from the saved pointer. On done, the current data pointer takes the saved pointer and the returned end-of-list flag becomes the current descriptor's flag. If bit 5 is also set, the channel then starts: state running, end-of-list flag cleared. Bits above 9 are ignored, and bit 5 on its own issues no request.
- R8: Stream-command bit 9 loads the context from the group-down pointer. On done, the saved pointer takes `eng_a` and the saved buffer takes `eng_b`. When the data bits are also set, the data load goes first.
- R9: A command write (continue) issues a request only when config bit0 is 1, config bit1 is 0, the state is running and the current descriptor's end-of-list flag is set. Otherwise it has no effect.
- R10: A continue reloads the descriptor at the saved pointer. If the returned flag is clear while the channel end-of-list flag is set, the saved pointer takes `eng_a`, a second load is made from it, the saved buffer takes that load's `eng_b`, and the channel starts. Otherwise the saved buffer takes `eng_b` of the first load.
- R11: `eng_req` stays high with stable `eng_op`, `eng_ch` and `eng_addr` until `eng_done`. Each done completes the request then presented. `eng_op` is 0 for a data load and 1 for a context load.
- R12: A full-width write to the command or stream-command register while a request is outstanding raises `bus_wait` and is not taken until the engine goes idle.
- R13: An access with any byte enable low is a narrow access. A narrow write is ignored and a narrow read returns 0. A narrow access sets the sticky `bus_err`, which only reset clears.
- R14: An engine event with `evt_end` set raises the channel end-of-list flag and the current descriptor's end-of-list flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | DW/8 | Byte enables, all set for a full access |
| bus_addr | input | 13+CH_W | Byte address: channel above bit 12 |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, same cycle |
| bus_wait | output | 1 | Write stalled while engine busy |
| bus_err | output | 1 | Sticky narrow-access flag |
| evt_valid | input | 1 | Engine event strobe |
| evt_ch | input | CH_W | Event channel |
| evt_cause | input | CAUSE_W | Cause bits to set |
| evt_end | input | 1 | Descriptor list ended |
| eng_req | output | 1 | Load request held until done |
| eng_op | output | 1 | 0 data load, 1 context load |
| eng_ch | output | CH_W | Requesting channel |
| eng_addr | output | DW | Descriptor address |
| eng_done | input | 1 | Request completed |
| eng_eol | input | 1 | Returned end-of-list flag |
| eng_a | input | DW | Next pointer or saved pointer |
| eng_b | input | DW | Buffer pointer or saved buffer |
| irq | output | NUM_CH | Per-channel interrupt |

## Verification
The bench builds the block with NUM_CH = 3, so the channel field is two bits wide and index 3 is an unused window. That exposes the out-of-range decode path, which a power-of-two count would remove. DW = 32 and CAUSE_W = 4 keep the status and cause fields at their full layout. A responder with a three-cycle latency returns descriptor fields computed from the request address, so single and chained continues, stacked stream loads and bus stalls all happen under real engine timing.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;
   localparam int CHAN_LSB = 13;
   localparam int IDX_W    = 6;

   localparam logic [IDX_W-1:0] IX_DATA  = 6'h00;
   localparam logic [IDX_W-1:0] IX_SAVED = 6'h16;
   localparam logic [IDX_W-1:0] IX_SBUF  = 6'h17;
   localparam logic [IDX_W-1:0] IX_GRP   = 6'h18;
   localparam logic [IDX_W-1:0] IX_GDOWN = 6'h1F;
   localparam logic [IDX_W-1:0] IX_CMD   = 6'h20;
   localparam logic [IDX_W-1:0] IX_CFG   = 6'h21;
   localparam logic [IDX_W-1:0] IX_STAT  = 6'h22;
   localparam logic [IDX_W-1:0] IX_MASK  = 6'h23;
   localparam logic [IDX_W-1:0] IX_ACK   = 6'h24;
   localparam logic [IDX_W-1:0] IX_RAW   = 6'h25;
   localparam logic [IDX_W-1:0] IX_MSKD  = 6'h26;
   localparam logic [IDX_W-1:0] IX_STRM  = 6'h27;

   localparam logic [9:0] STRM_LD_D  = 10'h140;
   localparam int         STRM_BURST = 5;
   localparam int         STRM_LD_C  = 9;

   typedef enum logic [2:0] {
      CH_RST  = 3'b001,
      CH_STOP = 3'b010,
      CH_RUN  = 3'b100
   } ch_state_t;

   typedef struct packed {
      logic load;
      logic buf_upd;
      logic next_upd;
      logic ctx;
      logic start;
   } upd_t;
endpackage

// File: rtl/dmaf_chan.sv
module dmaf_chan
   import dmaf_pkg::*;
#(
   parameter int DW      = 32,
   parameter int CAUSE_W = 4,
   parameter int SRC_ID  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   input  logic             evt_v,
   input  logic [CAUSE_W-1:0] evt_cause,
   input  logic             evt_end,
   input  upd_t             upd,
   input  logic             eng_eol,
   input  logic [DW-1:0]    eng_a,
   input  logic [DW-1:0]    eng_b,
   output logic [DW-1:0]    rdata,
   output logic             irq,
   output ch_state_t        state,
   output logic             ch_eol,
   output logic             cur_eol,
   output logic             cfg_en,
   output logic             cfg_stop,
   output logic [DW-1:0]    saved_ptr,
   output logic [DW-1:0]    gdown_ptr
);
   generate
      if (DW < 16 || (DW % 8) != 0) begin : g_bad_dw
         $error("dmaf_chan: DW must be a multiple of 8 and at least 16");
      end
      if (CAUSE_W < 1 || CAUSE_W > DW) begin : g_bad_cause
         $error("dmaf_chan: CAUSE_W out of range");
      end
   endgenerate

   logic [DW-1:0]      data_ptr, saved_buf, grp_ptr, cmd_q;
   logic [9:0]         strm_q;
   logic [1:0]         cfg_q;
   logic [CAUSE_W-1:0] mask_q, raw_q, raw_nx, masked, ack_bits;

   assign ack_bits = (wr_en && idx == IX_ACK) ? wdata[CAUSE_W-1:0] : '0;
   assign raw_nx   = (raw_q & ~ack_bits) | (evt_v ? evt_cause : '0);
   assign masked   = raw_q & mask_q;
   assign irq      = |masked;
   assign cfg_en   = cfg_q[0];
   assign cfg_stop = cfg_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_ptr  <= '0;
         saved_ptr <= '0;
         saved_buf <= '0;
         grp_ptr   <= '0;
         gdown_ptr <= '0;
         cmd_q     <= '0;
         strm_q    <= '0;
         cfg_q     <= '0;
         mask_q    <= '0;
         raw_q     <= '0;
         state     <= CH_RST;
         ch_eol    <= 1'b0;
         cur_eol   <= 1'b0;
      end else begin
         raw_q <= raw_nx;
         if (upd.load) begin
            data_ptr <= saved_ptr;
            cur_eol  <= eng_eol;
         end
         if (upd.next_upd) saved_ptr <= eng_a;
         if (upd.buf_upd)  saved_buf <= eng_b;
         if (upd.ctx) begin
            saved_ptr <= eng_a;
            saved_buf <= eng_b;
         end
         if (upd.start) begin
            ch_eol <= 1'b0;
            state  <= CH_RUN;
         end
         if (evt_v && evt_end) begin
            ch_eol  <= 1'b1;
            cur_eol <= 1'b1;
         end
         if (wr_en) begin
            case (idx)
               IX_DATA:  data_ptr  <= wdata;
               IX_SAVED: saved_ptr <= wdata;
               IX_SBUF:  saved_buf <= wdata;
               IX_GRP:   grp_ptr   <= wdata;
               IX_GDOWN: gdown_ptr <= wdata;
               IX_CMD:   cmd_q     <= wdata;
               IX_MASK:  mask_q    <= wdata[CAUSE_W-1:0];
               IX_STRM:  strm_q    <= wdata[9:0];
               IX_CFG: begin
                  cfg_q <= wdata[1:0];
                  if (wdata[1])  state <= CH_STOP;
                  if (!wdata[0]) state <= CH_RST;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (idx)
         IX_DATA:  rdata = data_ptr;
         IX_SAVED: rdata = saved_ptr;
         IX_SBUF:  rdata = saved_buf;
         IX_GRP:   rdata = grp_ptr;
         IX_GDOWN: rdata = gdown_ptr;
         IX_CMD:   rdata = cmd_q;
         IX_CFG:   rdata[1:0] = cfg_q;
         IX_STAT: begin
            rdata[2:0]  = state;
            rdata[5]    = ch_eol;
            rdata[15:8] = 8'(SRC_ID);
         end
         IX_MASK:  rdata[CAUSE_W-1:0] = mask_q;
         IX_RAW:   rdata[CAUSE_W-1:0] = raw_q;
         IX_MSKD:  rdata[CAUSE_W-1:0] = masked;
         IX_STRM:  rdata[9:0] = strm_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/dmaf_seq.sv
module dmaf_seq
   import dmaf_pkg::*;
#(
   parameter int CH_W = 1,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go_cont,
   input  logic            go_strm,
   input  logic [CH_W-1:0] go_ch,
   input  logic            strm_ld_d,
   input  logic            strm_burst,
   input  logic            strm_ld_c,
   input  logic [DW-1:0]   base_data,
   input  logic [DW-1:0]   base_ctx,
   input  logic            cur_ch_eol,
   input  logic            eng_done,
   input  logic            eng_eol,
   input  logic [DW-1:0]   eng_a,
   output logic            busy,
   output logic [CH_W-1:0] seq_ch,
   output logic            eng_req,
   output logic            eng_op,
   output logic [DW-1:0]   eng_addr,
   output upd_t            upd
);
   typedef enum logic [2:0] {S_IDLE, S_LD, S_CTX, S_C1, S_C2} seq_st_t;

   seq_st_t       st;
   logic [DW-1:0] addr_q;
   logic          op_q, burst_q, ctx_q;
   logic          chain;

   assign busy     = (st != S_IDLE);
   assign eng_req  = busy;
   assign eng_op   = op_q;
   assign eng_addr = addr_q;
   assign chain    = !eng_eol && cur_ch_eol;

   always_comb begin
      upd = '0;
      if (eng_done) begin
         case (st)
            S_LD: begin
               upd.load  = 1'b1;
               upd.start = burst_q;
            end
            S_CTX: upd.ctx = 1'b1;
            S_C1: begin
               upd.load     = 1'b1;
               upd.next_upd = chain;
               upd.buf_upd  = !chain;
            end
            S_C2: begin
               upd.load    = 1'b1;
               upd.buf_upd = 1'b1;
               upd.start   = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         seq_ch  <= '0;
         addr_q  <= '0;
         op_q    <= 1'b0;
         burst_q <= 1'b0;
         ctx_q   <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               if (go_cont) begin
                  seq_ch <= go_ch;
                  addr_q <= base_data;
                  op_q   <= 1'b0;
                  st     <= S_C1;
               end else if (go_strm) begin
                  seq_ch  <= go_ch;
                  burst_q <= strm_burst;
                  ctx_q   <= strm_ld_c;
                  if (strm_ld_d) begin
                     addr_q <= base_data;
                     op_q   <= 1'b0;
                     st     <= S_LD;
                  end else begin
                     addr_q <= base_ctx;
                     op_q   <= 1'b1;
                     st     <= S_CTX;
                  end
               end
            end
            S_LD: if (eng_done) begin
               if (ctx_q) begin
                  addr_q <= base_ctx;
                  op_q   <= 1'b1;
                  st     <= S_CTX;
               end else begin
                  st <= S_IDLE;
               end
            end
            S_CTX: if (eng_done) st <= S_IDLE;
            S_C1: if (eng_done) begin
               if (chain) begin
                  addr_q <= eng_a;
                  st     <= S_C2;
               end else begin
                  st <= S_IDLE;
               end
            end
            S_C2: if (eng_done) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dmaf_front.sv
module dmaf_front
   import dmaf_pkg::*;
#(
   parameter  int NUM_CH  = 2,
   parameter  int DW      = 32,
   parameter  int CAUSE_W = 4,
   parameter  int SRC_ID  = 1,
   localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W  = CHAN_LSB + CH_W,
   localparam int BE_W    = DW / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [BE_W-1:0]    bus_be,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   output logic               bus_wait,
   output logic               bus_err,
   input  logic               evt_valid,
   input  logic [CH_W-1:0]    evt_ch,
   input  logic [CAUSE_W-1:0] evt_cause,
   input  logic               evt_end,
   output logic               eng_req,
   output logic               eng_op,
   output logic [CH_W-1:0]    eng_ch,
   output logic [DW-1:0]      eng_addr,
   input  logic               eng_done,
   input  logic               eng_eol,
   input  logic [DW-1:0]      eng_a,
   input  logic [DW-1:0]      eng_b,
   output logic [NUM_CH-1:0]  irq
);
   generate
      if (NUM_CH < 1) begin : g_bad_num
         $error("dmaf_front: NUM_CH must be at least 1");
      end
   endgenerate

   logic [DW-1:0]    rd_a [NUM_CH];
   logic [DW-1:0]    sptr_a [NUM_CH];
   logic [DW-1:0]    gdn_a [NUM_CH];
   ch_state_t        st_a [NUM_CH];
   logic [NUM_CH-1:0] cheol_v, cureol_v, en_v, stop_v;
   logic [3*NUM_CH-1:0] st_all;

   logic              full, ch_ok, want_wr, wr_take, is_ctl, cont_ok, busy;
   logic              go_cont, go_strm;
   logic [CH_W-1:0]   bus_ch, seq_ch, sel_ch;
   logic [IDX_W-1:0]  idx;
   upd_t              upd;
   logic              unused_addr;

   assign full        = &bus_be;
   assign bus_ch      = bus_addr[ADDR_W-1:CHAN_LSB];
   assign idx         = bus_addr[7:2];
   assign unused_addr = ^{bus_addr[CHAN_LSB-1:8], bus_addr[1:0]};

   generate
      if (NUM_CH == (1 << CH_W)) begin : g_full_dec
         assign ch_ok = 1'b1;
      end else begin : g_part_dec
         assign ch_ok = (bus_ch < CH_W'(NUM_CH));
      end
   endgenerate

   assign want_wr  = bus_sel && bus_wr && full && ch_ok;
   assign is_ctl   = (idx == IX_CMD) || (idx == IX_STRM);
   assign bus_wait = want_wr && is_ctl && busy;
   assign wr_take  = want_wr && !bus_wait;
   assign cont_ok  = en_v[bus_ch] && !stop_v[bus_ch] && (st_a[bus_ch] == CH_RUN)
                     && cureol_v[bus_ch];
   assign go_cont  = wr_take && (idx == IX_CMD) && cont_ok;
   assign go_strm  = wr_take && (idx == IX_STRM)
                     && (|(bus_wdata[9:0] & (STRM_LD_D | 10'h200)));
   assign sel_ch   = busy ? seq_ch : bus_ch;
   assign eng_ch   = seq_ch;
   assign bus_rdata = (bus_sel && !bus_wr && full && ch_ok) ? rd_a[bus_ch] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 bus_err <= 1'b0;
      else if (bus_sel && !full)  bus_err <= 1'b1;
   end

   dmaf_seq #(.CH_W(CH_W), .DW(DW)) i_seq (
      .clk(clk), .rst_n(rst_n),
      .go_cont(go_cont), .go_strm(go_strm), .go_ch(bus_ch),
      .strm_ld_d(|(bus_wdata[9:0] & STRM_LD_D)),
      .strm_burst(bus_wdata[STRM_BURST]), .strm_ld_c(bus_wdata[STRM_LD_C]),
      .base_data(sptr_a[sel_ch]), .base_ctx(gdn_a[sel_ch]),
      .cur_ch_eol(cheol_v[seq_ch]),
      .eng_done(eng_done), .eng_eol(eng_eol), .eng_a(eng_a),
      .busy(busy), .seq_ch(seq_ch), .eng_req(eng_req), .eng_op(eng_op),
      .eng_addr(eng_addr), .upd(upd)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      upd_t upd_i;
      assign upd_i = (seq_ch == CH_W'(i)) ? upd : '0;
      assign st_all[3*i +: 3] = st_a[i];

      dmaf_chan #(.DW(DW), .CAUSE_W(CAUSE_W), .SRC_ID(SRC_ID)) i_chan (
         .clk(clk), .rst_n(rst_n),
         .wr_en(wr_take && bus_ch == CH_W'(i)), .idx(idx), .wdata(bus_wdata),
         .evt_v(evt_valid && evt_ch == CH_W'(i)), .evt_cause(evt_cause),
         .evt_end(evt_end), .upd(upd_i),
         .eng_eol(eng_eol), .eng_a(eng_a), .eng_b(eng_b),
         .rdata(rd_a[i]), .irq(irq[i]), .state(st_a[i]),
         .ch_eol(cheol_v[i]), .cur_eol(cureol_v[i]),
         .cfg_en(en_v[i]), .cfg_stop(stop_v[i]),
         .saved_ptr(sptr_a[i]), .gdown_ptr(gdn_a[i])
      );
   end
endmodule

// File: rtl/dmaf_front_chk.sv
module dmaf_front_chk #(
   parameter int NUM_CH = 2,
   parameter int DW     = 32,
   parameter int CH_W   = 1,
   parameter int BE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [BE_W-1:0]   bus_be,
   input logic [DW-1:0]     bus_rdata,
   input logic              bus_wait,
   input logic              bus_err,
   input logic              eng_req,
   input logic              eng_done,
   input logic              eng_op,
   input logic [CH_W-1:0]   eng_ch,
   input logic [DW-1:0]     eng_addr,
   input logic [3*NUM_CH-1:0] st_all
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req && !eng_done |=> eng_req && $stable(eng_addr) && $stable(eng_op)
                                && $stable(eng_ch)); // R11

   AST_WAIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wait |-> eng_req); // R12

   AST_NARROW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !(&bus_be) |=> bus_err); // R13

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> bus_err); // R13

   AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel && !bus_wr && !(&bus_be) |-> bus_rdata == '0); // R13

   for (genvar i = 0; i < NUM_CH; i++) begin : g_st
      AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot(st_all[3*i +: 3])); // R4
   end
endmodule

bind dmaf_front dmaf_front_chk #(
   .NUM_CH(NUM_CH), .DW(DW), .CH_W(CH_W), .BE_W(BE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_be(bus_be), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
   .bus_err(bus_err), .eng_req(eng_req), .eng_done(eng_done),
   .eng_op(eng_op), .eng_ch(eng_ch), .eng_addr(eng_addr), .st_all(st_all)
);

// File: tb/test_dmaf_front.sv
module test_dmaf_front;
   localparam int NCH = 3;
   localparam int CW  = 2;
   localparam int AW  = 15;
   localparam int LAT = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]    bus_be = 4'hF;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic          bus_wait, bus_err;
   logic          evt_valid = 1'b0, evt_end = 1'b0;
   logic [CW-1:0] evt_ch = '0;
   logic [3:0]    evt_cause = '0;
   logic          eng_req, eng_op;
   logic [CW-1:0] eng_ch;
   logic [31:0]   eng_addr;
   logic          eng_done = 1'b0, eng_eol = 1'b0;
   logic [31:0]   eng_a = '0, eng_b = '0;
   logic [NCH-1:0] irq;

   int n_chk = 0, n_bad = 0, n_req = 0, cnt = 0, viol = 0, last_stall = 0;
   logic [31:0] last_addr = '0, prev_addr = '0;
   logic        last_op = 1'b0, ended = 1'b0;
   logic [CW-1:0] last_ch = '0;

   always #10 clk = ~clk;

   dmaf_front #(.NUM_CH(NCH), .DW(32), .CAUSE_W(4), .SRC_ID(1)) i_dmaf_front (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_wait(bus_wait), .bus_err(bus_err),
      .evt_valid(evt_valid), .evt_ch(evt_ch), .evt_cause(evt_cause),
      .evt_end(evt_end), .eng_req(eng_req), .eng_op(eng_op),
      .eng_ch(eng_ch), .eng_addr(eng_addr), .eng_done(eng_done),
      .eng_eol(eng_eol), .eng_a(eng_a), .eng_b(eng_b), .irq(irq)
   );

   // Engine responder: data load returns eol = addr[2], next = addr+0x200,
   // buffer = addr^0xF000; context load returns addr+0x40 and addr+0x80.
   always @(negedge clk) begin
      if (eng_done) begin
         eng_done = 1'b0;
         cnt = 0;
      end else if (eng_req) begin
         if (cnt > 0 && eng_addr !== prev_addr) viol++;
         prev_addr = eng_addr;
         cnt++;
         if (cnt == LAT) begin
            eng_done = 1'b1;
            n_req++;
            last_addr = eng_addr;
            last_op = eng_op;
            last_ch = eng_ch;
            if (!eng_op) begin
               eng_eol = eng_addr[2];
               eng_a = eng_addr + 32'h200;
               eng_b = eng_addr ^ 32'h0000_F000;
            end else begin
               eng_eol = 1'b0;
               eng_a = eng_addr + 32'h40;
               eng_b = eng_addr + 32'h80;
            end
         end
      end else begin
         cnt = 0;
      end
   end

   function automatic logic [AW-1:0] ad(int ch, logic [7:0] off);
      return {CW'(ch), 5'b0, off};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int ch, logic [7:0] off, logic [31:0] v, logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(ch, off); bus_wdata = v; bus_be = be;
      last_stall = 0;
      #1;
      while (bus_wait) begin
         last_stall++;
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
   endtask

   task automatic rd(int ch, logic [7:0] off, output logic [31:0] v, input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ad(ch, off); bus_be = be;
      #1 v = bus_rdata;
      #1 bus_sel = 1'b0; bus_be = 4'hF;
   endtask

   task automatic rchk(string tag, int ch, logic [7:0] off, logic [31:0] exp);
      logic [31:0] v;
      rd(ch, off, v);
      chk(tag, v, exp);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (eng_req) @(negedge clk);
   endtask

   task automatic evt(int ch, logic [3:0] cause, logic fin);
      @(negedge clk);
      evt_valid = 1'b1; evt_ch = CW'(ch); evt_cause = cause; evt_end = fin;
      @(negedge clk);
      evt_valid = 1'b0; evt_cause = '0; evt_end = 1'b0;
   endtask

   task automatic t_reset();
      for (int c = 0; c < NCH; c++) begin
         rchk("R1 status", c, 8'h88, 32'h101);
         rchk("R1 data ptr", c, 8'h00, 32'h0);
      end
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 eng_req", 32'(eng_req), 32'h0);
      chk("R1 bus_err", 32'(bus_err), 32'h0);
      chk("R1 bus_wait", 32'(bus_wait), 32'h0);
   endtask

   task automatic t_regs();
      logic [7:0] offs [5] = '{8'h00, 8'h58, 8'h5C, 8'h60, 8'h7C};
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < 5; k++) wr(c, offs[k], 32'hA000_0000 + 32'(c * 16 + k));
      for (int c = 0; c < NCH; c++)
         for (int k = 0; k < 5; k++) rchk("R2 pointer readback", c, offs[k], 32'hA000_0000 + 32'(c * 16 + k));
      wr(3, 8'h60, 32'h1234_5678);
      rchk("R2 unused window reads 0", 3, 8'h60, 32'h0);
      rchk("R2 other channel untouched", 0, 8'h60, 32'hA000_0003);
   endtask

   task automatic t_cfg();
      wr(2, 8'h84, 32'h1); rchk("R3 enable keeps reset", 2, 8'h88, 32'h101);
      wr(2, 8'h84, 32'h3); rchk("R3 stop bit", 2, 8'h88, 32'h102);
      rchk("R3 cfg readback", 2, 8'h84, 32'h3);
      wr(2, 8'h84, 32'h2); rchk("R3 reset wins", 2, 8'h88, 32'h101);
      wr(2, 8'h84, 32'h3); wr(2, 8'h84, 32'h1);
      rchk("R4 state held at stopped", 2, 8'h88, 32'h102);
   endtask

   task automatic t_stream();
      int n0;
      wr(0, 8'h84, 32'h1);
      wr(0, 8'h58, 32'h1000);
      n0 = n_req;
      wr(0, 8'h9C, 32'h160);
      wait_idle();
      chk("R7 one request", 32'(n_req - n0), 32'd1);
      chk("R7 load address", last_addr, 32'h1000);
      chk("R7 data op", 32'(last_op), 32'h0);
      rchk("R7 data ptr", 0, 8'h00, 32'h1000);
      rchk("R7 burst starts", 0, 8'h88, 32'h104);
      n0 = n_req;
      wr(0, 8'h9C, 32'hC00);
      wr(0, 8'h9C, 32'h020);
      wait_idle();
      chk("R7 high or burst-only bits ignored", 32'(n_req - n0), 32'd0);
   endtask

   task automatic t_ctx();
      int n0;
      wr(0, 8'h7C, 32'h3000);
      wr(0, 8'h9C, 32'h200);
      wait_idle();
      chk("R8 ctx op", 32'(last_op), 32'h1);
      rchk("R8 saved ptr", 0, 8'h58, 32'h3040);
      rchk("R8 saved buf", 0, 8'h5C, 32'h3080);
      n0 = n_req;
      wr(0, 8'h9C, 32'h340);
      wait_idle();
      chk("R8 data then ctx", 32'(n_req - n0), 32'd2);
      chk("R8 ctx last", last_addr, 32'h3000);
      rchk("R8 data ptr from saved", 0, 8'h00, 32'h3040);
   endtask

   task automatic t_continue();
      int n0;
      n0 = n_req;
      wr(0, 8'h80, 32'h1);
      wait_idle();
      chk("R9 no eol no request", 32'(n_req - n0), 32'd0);
      evt(0, 4'h0, 1'b1);
      rchk("R14 eol flag in status", 0, 8'h88, 32'h124);
      wr(0, 8'h58, 32'h5000);
      n0 = n_req;
      wr(0, 8'h80, 32'h1);
      wait_idle();
      chk("R10 chained loads", 32'(n_req - n0), 32'd2);
      chk("R10 second address", last_addr, 32'h5200);
      rchk("R10 data ptr", 0, 8'h00, 32'h5200);
      rchk("R10 saved ptr", 0, 8'h58, 32'h5200);
      rchk("R10 saved buf", 0, 8'h5C, 32'h0000_A200);
      rchk("R10 restarted", 0, 8'h88, 32'h104);
      evt(0, 4'h0, 1'b1);
      wr(0, 8'h58, 32'h6004);
      n0 = n_req;
      wr(0, 8'h80, 32'h1);
      wait_idle();
      chk("R10 single reload", 32'(n_req - n0), 32'd1);
      rchk("R10 buf from first", 0, 8'h5C, 32'h0000_9004);
      rchk("R10 still at eol", 0, 8'h88, 32'h124);
      wr(0, 8'h84, 32'h3);
      n0 = n_req;
      wr(0, 8'h80, 32'h1);
      wait_idle();
      chk("R9 stopped no request", 32'(n_req - n0), 32'd0);
      rchk("R9 stopped status", 0, 8'h88, 32'h122);
   endtask

   task automatic t_irq();
      evt(1, 4'h5, 1'b0);
      rchk("R5 raw set", 1, 8'h94, 32'h5);
      chk("R5 irq masked off", 32'(irq[1]), 32'h0);
      wr(1, 8'h8C, 32'h4);
      rchk("R5 masked", 1, 8'h98, 32'h4);
      chk("R5 irq on", 32'(irq[1]), 32'h1);
      chk("R5 other irq off", 32'(irq[0]), 32'h0);
      wr(1, 8'h90, 32'h4);
      rchk("R6 ack clears", 1, 8'h94, 32'h1);
      chk("R6 irq off", 32'(irq[1]), 32'h0);
      rchk("R6 ack reads 0", 1, 8'h90, 32'h0);
      wr(1, 8'h94, 32'hF);
      rchk("R6 raw not writable", 1, 8'h94, 32'h1);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(1, 8'h90); bus_wdata = 32'h3;
      evt_valid = 1'b1; evt_ch = 2'd1; evt_cause = 4'h2;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; evt_valid = 1'b0; evt_cause = '0;
      rchk("R6 set beats ack", 1, 8'h94, 32'h2);
   endtask

   task automatic t_wait();
      int n0;
      wr(1, 8'h84, 32'h1);
      wr(1, 8'h58, 32'h7000);
      n0 = n_req;
      wr(1, 8'h9C, 32'h140);
      chk("R12 first write no stall", 32'(last_stall), 32'd0);
      wr(1, 8'h9C, 32'h140);
      chk("R12 second write stalled", 32'(last_stall > 0), 32'd1);
      wait_idle();
      chk("R12 both taken", 32'(n_req - n0), 32'd2);
      chk("R11 channel presented", 32'(last_ch), 32'd1);
      chk("R11 address stable while held", 32'(viol), 32'd0);
   endtask

   task automatic t_narrow();
      logic [31:0] v;
      wr(0, 8'h60, 32'hDEAD_BEEF, 4'b0011);
      rchk("R13 narrow write ignored", 0, 8'h60, 32'hA000_0003);
      rd(0, 8'h60, v, 4'b0111);
      chk("R13 narrow read zero", v, 32'h0);
      chk("R13 sticky error", 32'(bus_err), 32'h1);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_cfg();
      t_stream();
      t_ctx();
      t_continue();
      t_irq();
      t_wait();
      t_narrow();
      finish_run();
   end
endmodule